// File: doc/BRIEF.md
# Latched Dual Interval Timer

This block holds two 16-bit down-counters that a host reaches through byte-wide register accesses at indices 4 to 9. The first counter has a full 16-bit reload latch. It runs continuously, counting from its loaded value through zero and on to all-ones, then reloading from the latch. Its period is therefore the latch value plus two ticks. When the mode field is set to free-running, it raises a set-pulse toward the interrupt register each time it reaches zero. The second counter is a one-shot: it is loaded from a low-byte latch together with a written high byte. It decrements and wraps without reloading, and it flags only the first zero it reaches after each load.

Both counters advance only on cycles where the tick enable is high. The host side is a plain single-cycle register port. A write takes effect at the next clock edge. Read data is combinational from the current state, so the host can capture it in the same cycle. The flag outputs are single-cycle strobes: set-pulses that mark counter events, and clear-pulses caused by the acknowledging accesses. A downstream interrupt register combines them and applies its own masking. There is no data stream here, so there is no valid/ready handshake. A set-pulse and a clear-pulse can occur in the same cycle, and the block reports both.

Top module: `dual_interval_timer`

## Requirements
- R1: On each tick the first counter decrements by one. After a load of value L, the counter passes through 0 and then 0xFFFF, and on the tick after 0xFFFF it reloads the latch value, so the sequence repeats every L+2 ticks.
- R2: `t1_set` pulses during a tick cycle whose edge brings the first counter to zero, either by decrement or by reload of a zero latch, but only when `t1_mode` equals 2'b01. For any other mode value it never pulses.
- R3: A write at index 4 or index 6 replaces only the low latch byte of the first counter. The counter value is unchanged.
- R4: A write at index 5 sets the high latch byte, pulses `t1_clr` in that cycle, and loads the counter with {written byte, low latch byte}. This load takes precedence over a tick in the same cycle.
- R5: A write at index 7 sets the high latch byte and pulses `t1_clr` in that cycle. The counter value is unchanged.
- R6: Reads return the following: index 4 gives counter bits 7:0, index 5 gives counter bits 15:8, index 6 gives latch bits 7:0, and index 7 gives latch bits 15:8. A read at index 4 pulses `t1_clr`; a read at index 5 does not.
- R7: A write at index 8 stores the second counter's low latch byte. A write at index 9 loads the second counter with {written byte, low latch byte} and arms its flag.
- R8: The second counter decrements once per tick and wraps from 0 to 0xFFFF without reloading. `t2_set` pulses on the tick that brings it from 1 to 0 only once after each load. Reads at index 8 and index 9 return its low and high bytes, and only the index-8 read pulses `t2_clr`.
- R9: With `tick_en` low and no load write, neither counter changes value.
- R10: After reset, the first counter and its latch are 0xFFFF, the second counter is 0xFFFF, its low latch byte is 0x00, and its flag is disarmed.
- R11: When an acknowledging read at index 4 falls in the same tick cycle in which the first counter reaches zero, both `t1_set` and `t1_clr` are high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable; both counters advance on cycles where it is high |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_idx | input | 4 | Register index (4 to 9 are decoded) |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 8 | Read data byte, combinational, 0 for undecoded indices |
| t1_mode | input | 2 | Mode bits of the auxiliary control register; 2'b01 selects free-running flagging |
| t1_set | output | 1 | First-counter flag set-pulse |
| t1_clr | output | 1 | First-counter flag clear-pulse |
| t2_set | output | 1 | Second-counter flag set-pulse |
| t2_clr | output | 1 | Second-counter flag clear-pulse |

## Verification
Two kinds of event can land in the same cycle. The first is a counter event against a host access: a tick that brings the first counter to zero can coincide with the acknowledging read at index 4. The bench steps the counter to 1 and then issues the tick and that read together. It expects both strobes high and the read byte to show 1. The second is a reload write against a tick: a write at index 5 issued with `tick_en` high must leave the counter at the latch value rather than one below it.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_T1_CNT_LO = 4'd4;
  localparam logic [IDX_W-1:0] IDX_T1_CNT_HI = 4'd5;
  localparam logic [IDX_W-1:0] IDX_T1_LAT_LO = 4'd6;
  localparam logic [IDX_W-1:0] IDX_T1_LAT_HI = 4'd7;
  localparam logic [IDX_W-1:0] IDX_T2_LO     = 4'd8;
  localparam logic [IDX_W-1:0] IDX_T2_HI     = 4'd9;

  localparam logic [1:0] MODE_FREE_RUN = 2'b01;

  typedef struct packed {
    logic t1_lat_lo_wr;
    logic t1_load_wr;
    logic t1_lat_hi_wr;
    logic t2_lat_wr;
    logic t2_load_wr;
    logic t1_ack_rd;
    logic t2_ack_rd;
  } dit_strobe_t;
endpackage

// File: rtl/dit_decode.sv
module dit_decode
  import dit_pkg::*;
(
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic [IDX_W-1:0] acc_idx,
  output dit_strobe_t      strb
);
  always_comb begin
    strb = '0;
    strb.t1_lat_lo_wr = acc_wr && (acc_idx == IDX_T1_CNT_LO || acc_idx == IDX_T1_LAT_LO);
    strb.t1_load_wr   = acc_wr && (acc_idx == IDX_T1_CNT_HI);
    strb.t1_lat_hi_wr = acc_wr && (acc_idx == IDX_T1_LAT_HI);
    strb.t2_lat_wr    = acc_wr && (acc_idx == IDX_T2_LO);
    strb.t2_load_wr   = acc_wr && (acc_idx == IDX_T2_HI);
    strb.t1_ack_rd    = acc_rd && (acc_idx == IDX_T1_CNT_LO);
    strb.t2_ack_rd    = acc_rd && (acc_idx == IDX_T2_LO);
  end
endmodule

// File: rtl/dit_reload_timer.sv
module dit_reload_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              free_run,
  input  logic              lat_lo_wr,
  input  logic              load_wr,
  input  logic              lat_hi_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  latch,
  output logic              zero_set
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic past_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch    <= '1;
      cnt      <= '1;
      past_end <= 1'b0;
    end else begin
      if (lat_lo_wr) latch[BYTE_W-1:0] <= wdata;
      if (load_wr || lat_hi_wr) latch[CNT_W-1:BYTE_W] <= wdata;
      if (load_wr) begin
        cnt      <= {wdata, latch[BYTE_W-1:0]};
        past_end <= 1'b0;
      end else if (tick) begin
        if (past_end) begin
          cnt      <= latch;
          past_end <= 1'b0;
        end else begin
          cnt      <= cnt - ONE;
          past_end <= (cnt == '0);
        end
      end
    end
  end

  assign zero_set = free_run && tick && !load_wr &&
                    (past_end ? (latch == '0) : (cnt == ONE));
endmodule

// File: rtl/dit_oneshot_timer.sv
module dit_oneshot_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lat_wr,
  input  logic              load_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] lat_lo,
  output logic              zero_set
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '1;
      lat_lo <= '0;
      armed  <= 1'b0;
    end else begin
      if (lat_wr) lat_lo <= wdata;
      if (load_wr) begin
        cnt   <= {wdata, lat_lo};
        armed <= 1'b1;
      end else if (tick) begin
        cnt <= cnt - ONE;
        if (cnt == ONE) armed <= 1'b0;
      end
    end
  end

  assign zero_set = tick && !load_wr && armed && (cnt == ONE);
endmodule

// File: rtl/dit_read_mux.sv
module dit_read_mux
  import dit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [CNT_W-1:0]  t1_cnt,
  input  logic [CNT_W-1:0]  t1_latch,
  input  logic [CNT_W-1:0]  t2_cnt,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    unique case (acc_idx)
      IDX_T1_CNT_LO: rdata = t1_cnt[BYTE_W-1:0];
      IDX_T1_CNT_HI: rdata = t1_cnt[CNT_W-1:BYTE_W];
      IDX_T1_LAT_LO: rdata = t1_latch[BYTE_W-1:0];
      IDX_T1_LAT_HI: rdata = t1_latch[CNT_W-1:BYTE_W];
      IDX_T2_LO:     rdata = t2_cnt[BYTE_W-1:0];
      IDX_T2_HI:     rdata = t2_cnt[CNT_W-1:BYTE_W];
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] acc_rdata,
  input  logic [1:0]        t1_mode,
  output logic              t1_set,
  output logic              t1_clr,
  output logic              t2_set,
  output logic              t2_clr
);
  dit_strobe_t       strb;
  logic [CNT_W-1:0]  t1_cnt;
  logic [CNT_W-1:0]  t1_latch;
  logic [CNT_W-1:0]  t2_cnt;
  logic [BYTE_W-1:0] t2_lat_lo;

  dit_decode u_decode (
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd),
    .acc_idx (acc_idx),
    .strb    (strb)
  );

  dit_reload_timer #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_t1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .free_run  (t1_mode == MODE_FREE_RUN),
    .lat_lo_wr (strb.t1_lat_lo_wr),
    .load_wr   (strb.t1_load_wr),
    .lat_hi_wr (strb.t1_lat_hi_wr),
    .wdata     (acc_wdata),
    .cnt       (t1_cnt),
    .latch     (t1_latch),
    .zero_set  (t1_set)
  );

  dit_oneshot_timer #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_t2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .lat_wr   (strb.t2_lat_wr),
    .load_wr  (strb.t2_load_wr),
    .wdata    (acc_wdata),
    .cnt      (t2_cnt),
    .lat_lo   (t2_lat_lo),
    .zero_set (t2_set)
  );

  dit_read_mux #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rmux (
    .acc_idx  (acc_idx),
    .t1_cnt   (t1_cnt),
    .t1_latch (t1_latch),
    .t2_cnt   (t2_cnt),
    .rdata    (acc_rdata)
  );

  assign t1_clr = strb.t1_load_wr || strb.t1_lat_hi_wr || strb.t1_ack_rd;
  assign t2_clr = strb.t2_ack_rd;
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic [IDX_W-1:0]  acc_idx,
  input logic [BYTE_W-1:0] acc_wdata,
  input logic [1:0]        t1_mode,
  input logic              t1_set,
  input logic              t1_clr,
  input logic [CNT_W-1:0]  t1_cnt,
  input logic [CNT_W-1:0]  t1_latch,
  input logic [CNT_W-1:0]  t2_cnt,
  input logic [BYTE_W-1:0] t2_lat_lo
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic t1_load_req;
  assign t1_load_req = acc_wr && acc_idx == IDX_T1_CNT_HI;

  AST_T1_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !t1_load_req && t1_cnt != '1 |=> t1_cnt == $past(t1_cnt) - ONE); // R1

  AST_T1_SET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    t1_set |-> t1_mode == MODE_FREE_RUN); // R2

  AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    t1_load_req |=> t1_cnt == {$past(acc_wdata), $past(t1_latch[BYTE_W-1:0])}); // R4

  AST_T1_ACK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && acc_idx == IDX_T1_CNT_LO |-> t1_clr); // R6

  AST_T2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && acc_idx == IDX_T2_HI |=> t2_cnt == {$past(acc_wdata), $past(t2_lat_lo)}); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !acc_wr |=> $stable(t1_cnt) && $stable(t2_cnt)); // R9
endmodule

bind dual_interval_timer dit_checker #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dit_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .acc_wr    (acc_wr),
  .acc_rd    (acc_rd),
  .acc_idx   (acc_idx),
  .acc_wdata (acc_wdata),
  .t1_mode   (t1_mode),
  .t1_set    (t1_set),
  .t1_clr    (t1_clr),
  .t1_cnt    (t1_cnt),
  .t1_latch  (t1_latch),
  .t2_cnt    (t2_cnt),
  .t2_lat_lo (t2_lat_lo)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, acc_wr, acc_rd;
  logic [3:0] acc_idx;
  logic [7:0] acc_wdata, acc_rdata;
  logic [1:0] t1_mode;
  logic       t1_set, t1_clr, t2_set, t2_clr;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  logic       cap_s1, cap_c1, cap_s2, cap_c2;
  logic [7:0] cap_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .t1_mode(t1_mode),
    .t1_set(t1_set), .t1_clr(t1_clr), .t2_set(t2_set), .t2_clr(t2_clr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic wr, input logic rd,
                      input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    tick_en = tk; acc_wr = wr; acc_rd = rd; acc_idx = idx; acc_wdata = d;
    #1;
    cap_s1 = t1_set; cap_c1 = t1_clr; cap_s2 = t2_set; cap_c2 = t2_clr; cap_rd = acc_rdata;
    @(posedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b0, idx, d);
  endtask

  task automatic rd16(input logic [3:0] lo_idx, output int v);
    int lo;
    step(1'b0, 1'b0, 1'b1, lo_idx, 8'h00);
    lo = int'(cap_rd);
    step(1'b0, 1'b0, 1'b1, lo_idx + 4'd1, 8'h00);
    v = (int'(cap_rd) << 8) | lo;
  endtask

  function automatic int t1_model(input int lat, input int n);
    if (n <= lat + 1) return (lat - n) & 'hFFFF;
    return (lat - ((n - lat - 2) % (lat + 2))) & 'hFFFF;
  endfunction

  initial begin
    int v;
    int pulses;
    rst_n = 1'b0; tick_en = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0;
    acc_idx = 4'd0; acc_wdata = 8'h00; t1_mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset values
    for (int i = 4; i <= 9; i++) begin
      step(1'b0, 1'b0, 1'b1, 4'(i), 8'h00);
      chk("R10 reset byte", int'(cap_rd), 'hFF);
    end
    wr_reg(4'd9, 8'h34);
    rd16(4'd8, v);
    chk("R10 t2 low latch reset zero / R7 load", v, 'h3400);

    // R1 R2 R3 R4: period sweep in both modes
    for (int m = 0; m < 2; m++) begin
      t1_mode = (m == 0) ? 2'b01 : 2'b00;
      for (int lat = 0; lat <= 6; lat++) begin
        wr_reg(4'd4, 8'(lat));
        step(1'b0, 1'b1, 1'b0, 4'd5, 8'h00);
        chk("R4 load clears flag", int'(cap_c1), 1);
        rd16(4'd4, v);
        chk("R4 load copies latch", v, lat);
        for (int n = 1; n <= 2 * lat + 5; n++) begin
          step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
          chk("R2 zero flag", int'(cap_s1), (m == 0 && t1_model(lat, n) == 0) ? 1 : 0);
          rd16(4'd4, v);
          chk("R1 count sequence", v, t1_model(lat, n));
        end
      end
    end

    // R3 R5: latch-only writes
    t1_mode = 2'b01;
    wr_reg(4'd4, 8'h10);
    wr_reg(4'd5, 8'h00);
    repeat (3) step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    wr_reg(4'd6, 8'h55);
    rd16(4'd4, v);
    chk("R3 counter untouched", v, 'h000D);
    step(1'b0, 1'b0, 1'b1, 4'd6, 8'h00);
    chk("R3 latch low", int'(cap_rd), 'h55);
    step(1'b0, 1'b1, 1'b0, 4'd7, 8'h12);
    chk("R5 clear pulse", int'(cap_c1), 1);
    rd16(4'd4, v);
    chk("R5 counter untouched", v, 'h000D);
    step(1'b0, 1'b0, 1'b1, 4'd7, 8'h00);
    chk("R5 latch high", int'(cap_rd), 'h12);
    step(1'b0, 1'b0, 1'b1, 4'd5, 8'h00);
    chk("R6 high read no clear", int'(cap_c1), 0);

    // R4: load write beats same-cycle tick
    step(1'b1, 1'b1, 1'b0, 4'd5, 8'h00);
    chk("R4 no zero flag on load", int'(cap_s1), 0);
    rd16(4'd4, v);
    chk("R4 load wins over tick", v, 'h0055);

    // R11: acknowledge read and zero crossing together
    wr_reg(4'd4, 8'h03);
    wr_reg(4'd5, 8'h00);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    step(1'b1, 1'b0, 1'b1, 4'd4, 8'h00);
    chk("R11 set pulse", int'(cap_s1), 1);
    chk("R11 clear pulse", int'(cap_c1), 1);
    chk("R6 low read value", int'(cap_rd), 'h01);

    // R9: idle holds
    repeat (5) step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    rd16(4'd4, v);
    chk("R9 t1 hold", v, 0);

    // R7 R8: one-shot behaviour
    wr_reg(4'd8, 8'h02);
    wr_reg(4'd9, 8'h00);
    rd16(4'd8, v);
    chk("R7 t2 load", v, 2);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R8 no early flag", int'(cap_s2), 0);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R8 flag at zero", int'(cap_s2), 1);
    repeat (4) step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    rd16(4'd8, v);
    chk("R9 t2 hold", v, 0);
    pulses = 0;
    for (int n = 0; n < 65536; n++) begin
      step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
      if (cap_s2) pulses++;
    end
    chk("R8 single flag per load", pulses, 0);
    rd16(4'd8, v);
    chk("R8 wraps without reload", v, 0);
    step(1'b0, 1'b0, 1'b1, 4'd8, 8'h00);
    chk("R8 low read clears", int'(cap_c2), 1);
    step(1'b0, 1'b0, 1'b1, 4'd9, 8'h00);
    chk("R8 high read no clear", int'(cap_c2), 0);

    step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule